// File: doc/BRIEF.md
# SMBus Host Command and Status Register Front End

This block is the software-facing register set of an SMBus host controller. Software reaches three byte-wide registers over a simple register bus: a host control register, a host status register and an auxiliary feature register. Writing the control register with its start bit set launches a transaction towards a bus-side engine. The engine is modelled here as a request/response interface: it receives a one-cycle request with the command type, and reports back completion, device no-response, bus collision, byte completion, the end of the packet-error-check (PEC) phase and alert events.

The status register collects these events as sticky flags that software clears by writing ones. A host-busy flag covers the whole transaction. A kill bit aborts a transaction in progress. The auxiliary register gates the PEC and 32-byte block-buffer features. Software polls host-busy and gives up after its own timeout. It then sets and later clears the kill bit. Two summary outputs give the "ready to start" and "fatal during transfer" conditions that software tests before and during a block transfer.

Register addresses: 0 = status, 1 = control, 2 = auxiliary. Address 3 reads as 0 and ignores writes. Read data is combinational from the address.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset, the status, control and auxiliary registers read 0x00, host_ready is 1 and xfer_fatal is 0.
- R2: A control write with bit 6 (start) set while idle and bit 1 (kill) clear sets status bit 0 (host-busy) on the next cycle. It pulses eng_req for exactly one cycle and presents control bits 5:2 on eng_cmd. The control register reads back bit 7 (PEC request), bits 5:2 (command) and bit 1 (kill), with bit 6 always reading 0.
- R3: A start write while host-busy is set produces no eng_req, leaves host-busy set and leaves eng_cmd unchanged.
- R4: eng_done during a transaction clears host-busy. If no error is reported in that cycle and PEC is not active, it sets status bit 1 (interrupt).
- R5: eng_dev_err sets status bit 2 and eng_coll sets status bit 3 during a transaction. A completion that carries an error does not set the interrupt bit.
- R6: Writing control bit 1 (kill) as 1 while busy clears host-busy on the next cycle, sets status bit 4 (failed) and pulses eng_abort for one cycle. A start written together with the kill bit set launches nothing.
- R7: Status bits 7..1 clear when written with 1 and are unchanged when written with 0. Writes never change bit 0 (host-busy).
- R8: PEC is active for a transaction when control bit 7 and auxiliary bit 0 are both set at launch, and eng_pec_en shows that AND. For such a transaction eng_done does not set the interrupt bit; a later eng_pec_done does.
- R9: Auxiliary bit 0 (CRC enable) and bit 1 (block-buffer enable) read back as written, with bits 7..2 reading 0. eng_blkbuf_en follows bit 1. With BLOCK_BUF_PRESENT = 0, bit 1 cannot be set and reads 0.
- R10: A status read while status bit 6 (in-use) is clear returns it as 0 and sets it for later reads. Writing 1 to bit 6 clears it.
- R11: eng_byte_done sets status bit 7 (byte-done) only while busy. eng_alert sets status bit 5 (alert) at any time.
- R12: host_ready is 1 exactly when status bits under mask 0x9F are all 0. xfer_fatal is 1 when any status bit under mask 0x1E is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks a software read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| eng_req | output | 1 | One-cycle transaction request to the engine |
| eng_cmd | output | 4 | Command type latched at launch |
| eng_pec_en | output | 1 | PEC requested and enabled |
| eng_blkbuf_en | output | 1 | Block buffer enabled |
| eng_abort | output | 1 | One-cycle abort request |
| eng_done | input | 1 | Engine finished the transaction |
| eng_dev_err | input | 1 | Device did not respond |
| eng_coll | input | 1 | Bus collision detected |
| eng_byte_done | input | 1 | One byte transferred |
| eng_pec_done | input | 1 | PEC phase finished |
| eng_alert | input | 1 | Alert seen on the bus |
| host_ready | output | 1 | No flag under mask 0x9F set |
| xfer_fatal | output | 1 | A flag under mask 0x1E set |

## Verification
Transactions are launched with different command codes and then closed in four ways: clean completion, completion with device error plus collision, kill from software, and completion followed by a PEC-phase end. These show which event sets the interrupt flag and which does not. Start writes are also issued while busy and with the kill bit held, which shows that the launch guard works apart from the ordinary start path. Status writes with single bits and with all bits set show that each flag clears on its own and that host-busy cannot be written. Reads of the in-use flag separate the first read from later ones.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int CMD_W  = 4;

    localparam logic [ADDR_W-1:0] A_STS = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTL = 2'd1;
    localparam logic [ADDR_W-1:0] A_AUX = 2'd2;

    // status bit positions (software decodes these)
    localparam int S_BUSY  = 0;
    localparam int S_INTR  = 1;
    localparam int S_DEV   = 2;
    localparam int S_COLL  = 3;
    localparam int S_FAIL  = 4;
    localparam int S_ALERT = 5;
    localparam int S_INUSE = 6;
    localparam int S_BYTE  = 7;

    // control bit positions
    localparam int C_KILL  = 1;
    localparam int C_CMDLO = 2;
    localparam int C_START = 6;
    localparam int C_PEC   = 7;

    localparam logic [REG_W-1:0] READY_MASK = 8'h9F;
    localparam logic [REG_W-1:0] FATAL_MASK = 8'h1E;

    typedef struct packed {
        logic [REG_W-1:0] flags;
        logic             pec_act;
    } sts_state_t;

    typedef struct packed {
        logic             pec;
        logic [CMD_W-1:0] cmd;
        logic             kill;
        logic [CMD_W-1:0] xcmd;
        logic             req;
        logic             abort;
    } ctl_state_t;

    typedef struct packed {
        logic crc;
        logic blk;
    } aux_state_t;
endpackage

// File: rtl/smbh_aux_reg.sv
module smbh_aux_reg
    import smbh_pkg::*;
#(
    parameter bit BLOCK_BUF_PRESENT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_aux,
    input  logic [REG_W-1:0] wdata,
    output logic             crc_en,
    output logic             blk_en
);
    aux_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_aux) begin
            st_d.crc = wdata[0];
            st_d.blk = BLOCK_BUF_PRESENT ? wdata[1] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_en = st_q.crc;
    assign blk_en = st_q.blk;

    generate
        if (!BLOCK_BUF_PRESENT) begin : g_noblk
            assert_noblk_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !blk_en);
        end
    endgenerate

    assert_aux_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_aux |=> (crc_en == $past(wdata[0])));
endmodule

// File: rtl/smbh_ctl_reg.sv
module smbh_ctl_reg
    import smbh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy_i,
    input  logic             aux_crc_i,
    output logic             launch,
    output logic             launch_pec,
    output logic             kill_fire,
    output logic [REG_W-1:0] ctl_rd,
    output logic             pec_req,
    output logic [CMD_W-1:0] xcmd,
    output logic             req,
    output logic             abort
);
    ctl_state_t st_d, st_q;

    always_comb begin
        launch     = wr_ctl && wdata[C_START] && !busy_i && !wdata[C_KILL];
        launch_pec = wdata[C_PEC] && aux_crc_i;
        kill_fire  = wr_ctl && wdata[C_KILL] && busy_i;

        st_d       = st_q;
        st_d.req   = launch;
        st_d.abort = kill_fire;
        if (wr_ctl) begin
            st_d.pec  = wdata[C_PEC];
            st_d.cmd  = wdata[C_CMDLO +: CMD_W];
            st_d.kill = wdata[C_KILL];
        end
        if (launch) st_d.xcmd = wdata[C_CMDLO +: CMD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctl_rd                   = '0;
        ctl_rd[C_PEC]            = st_q.pec;
        ctl_rd[C_CMDLO +: CMD_W] = st_q.cmd;
        ctl_rd[C_KILL]           = st_q.kill;
    end

    assign pec_req = st_q.pec;
    assign xcmd    = st_q.xcmd;
    assign req     = st_q.req;
    assign abort   = st_q.abort;

    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    assert_req_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !$past(busy_i));
    assert_abort_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);
endmodule

// File: rtl/smbh_sts_reg.sv
module smbh_sts_reg
    import smbh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             rd_sts,
    input  logic [REG_W-1:0] wdata,
    input  logic             launch,
    input  logic             launch_pec,
    input  logic             kill_fire,
    input  logic             eng_done,
    input  logic             eng_dev_err,
    input  logic             eng_coll,
    input  logic             eng_byte_done,
    input  logic             eng_pec_done,
    input  logic             eng_alert,
    output logic [REG_W-1:0] flags,
    output logic             busy
);
    sts_state_t st_d, st_q;
    logic       ending, clean_end;

    always_comb begin
        ending    = st_q.flags[S_BUSY] && eng_done && !kill_fire;
        clean_end = ending && !eng_dev_err && !eng_coll;

        st_d = st_q;
        // write-one-to-clear, host-busy excluded
        if (wr_sts) st_d.flags[REG_W-1:1] = st_q.flags[REG_W-1:1] & ~wdata[REG_W-1:1];

        // sets take priority over clears in the same cycle
        if (st_q.flags[S_BUSY] && eng_byte_done) st_d.flags[S_BYTE] = 1'b1;
        if (st_q.flags[S_BUSY] && eng_dev_err)   st_d.flags[S_DEV]  = 1'b1;
        if (st_q.flags[S_BUSY] && eng_coll)      st_d.flags[S_COLL] = 1'b1;
        if (eng_alert)                           st_d.flags[S_ALERT] = 1'b1;
        if (kill_fire)                           st_d.flags[S_FAIL] = 1'b1;
        if (rd_sts && !st_q.flags[S_INUSE])      st_d.flags[S_INUSE] = 1'b1;

        if (clean_end && !st_q.pec_act)          st_d.flags[S_INTR] = 1'b1;
        if (st_q.pec_act && eng_pec_done)        st_d.flags[S_INTR] = 1'b1;

        if (launch)         st_d.flags[S_BUSY] = 1'b1;
        else if (kill_fire) st_d.flags[S_BUSY] = 1'b0;
        else if (ending)    st_d.flags[S_BUSY] = 1'b0;

        if (launch)                                st_d.pec_act = launch_pec;
        else if (kill_fire)                        st_d.pec_act = 1'b0;
        else if (ending && !clean_end)             st_d.pec_act = 1'b0;
        else if (st_q.pec_act && eng_pec_done)     st_d.pec_act = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign busy  = st_q.flags[S_BUSY];

    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));
    assert_kill_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kill_fire |=> (!busy && flags[S_FAIL]));
    assert_err_no_intr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && eng_dev_err && !flags[S_INTR] && !eng_pec_done)
        |=> !flags[S_INTR]);
    assert_w1c_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && wdata[S_FAIL] && !kill_fire) |=> !flags[S_FAIL]);
    assert_inuse_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !flags[S_INUSE]) |=> flags[S_INUSE]);
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter bit BLOCK_BUF_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              eng_req,
    output logic [CMD_W-1:0]  eng_cmd,
    output logic              eng_pec_en,
    output logic              eng_blkbuf_en,
    output logic              eng_abort,
    input  logic              eng_done,
    input  logic              eng_dev_err,
    input  logic              eng_coll,
    input  logic              eng_byte_done,
    input  logic              eng_pec_done,
    input  logic              eng_alert,
    output logic              host_ready,
    output logic              xfer_fatal
);
    logic             wr_sts, rd_sts, wr_ctl, wr_aux;
    logic             launch, launch_pec, kill_fire, busy;
    logic             aux_crc, aux_blk, pec_req;
    logic [REG_W-1:0] sts_flags, ctl_rd;

    assign wr_sts = reg_wr && (reg_addr == A_STS);
    assign rd_sts = reg_rd && (reg_addr == A_STS);
    assign wr_ctl = reg_wr && (reg_addr == A_CTL);
    assign wr_aux = reg_wr && (reg_addr == A_AUX);

    smbh_aux_reg #(.BLOCK_BUF_PRESENT(BLOCK_BUF_PRESENT)) u_aux (
        .clk(clk), .rst_n(rst_n), .wr_aux(wr_aux), .wdata(reg_wdata),
        .crc_en(aux_crc), .blk_en(aux_blk)
    );

    smbh_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(reg_wdata),
        .busy_i(busy), .aux_crc_i(aux_crc),
        .launch(launch), .launch_pec(launch_pec), .kill_fire(kill_fire),
        .ctl_rd(ctl_rd), .pec_req(pec_req), .xcmd(eng_cmd),
        .req(eng_req), .abort(eng_abort)
    );

    smbh_sts_reg u_sts (
        .clk(clk), .rst_n(rst_n), .wr_sts(wr_sts), .rd_sts(rd_sts),
        .wdata(reg_wdata), .launch(launch), .launch_pec(launch_pec),
        .kill_fire(kill_fire), .eng_done(eng_done), .eng_dev_err(eng_dev_err),
        .eng_coll(eng_coll), .eng_byte_done(eng_byte_done),
        .eng_pec_done(eng_pec_done), .eng_alert(eng_alert),
        .flags(sts_flags), .busy(busy)
    );

    always_comb begin
        unique case (reg_addr)
            A_STS:   reg_rdata = sts_flags;
            A_CTL:   reg_rdata = ctl_rd;
            A_AUX:   reg_rdata = {{(REG_W-2){1'b0}}, aux_blk, aux_crc};
            default: reg_rdata = '0;
        endcase
    end

    assign eng_pec_en    = pec_req && aux_crc;
    assign eng_blkbuf_en = aux_blk;
    assign host_ready    = (sts_flags & READY_MASK) == '0;
    assign xfer_fatal    = |(sts_flags & FATAL_MASK);

    assert_ready_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_ready);
endmodule

// File: tb/tb_smbus_host_regs.sv
module tb_smbus_host_regs;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_pec_en, eng_blkbuf_en, eng_abort;
    logic [3:0] eng_cmd;
    logic       eng_done = 0, eng_dev_err = 0, eng_coll = 0;
    logic       eng_byte_done = 0, eng_pec_done = 0, eng_alert = 0;
    logic       host_ready, xfer_fatal;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_host_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_pec_en(eng_pec_en),
        .eng_blkbuf_en(eng_blkbuf_en), .eng_abort(eng_abort),
        .eng_done(eng_done), .eng_dev_err(eng_dev_err), .eng_coll(eng_coll),
        .eng_byte_done(eng_byte_done), .eng_pec_done(eng_pec_done),
        .eng_alert(eng_alert), .host_ready(host_ready), .xfer_fatal(xfer_fatal)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // status read with the in-use bit hidden
    task automatic rd_sts(output logic [7:0] d);
        logic [7:0] t;
        rd(2'd0, t);
        d = t & 8'hBF;
    endtask

    task automatic pulse(input logic done, input logic dev, input logic coll,
                         input logic byt, input logic pecd, input logic alrt);
        eng_done = done; eng_dev_err = dev; eng_coll = coll;
        eng_byte_done = byt; eng_pec_done = pecd; eng_alert = alrt;
        @(negedge clk);
        {eng_done, eng_dev_err, eng_coll, eng_byte_done, eng_pec_done, eng_alert} = '0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check("R1 status", v, 8'h00);
        rd(2'd1, v); check("R1 control", v, 8'h00);
        rd(2'd2, v); check("R1 aux", v, 8'h00);
        check("R1 ready", {7'b0, host_ready}, 8'h01);
        check("R1 fatal", {7'b0, xfer_fatal}, 8'h00);
        wr(2'd0, 8'h40);
    endtask

    task automatic t_launch;
        logic [7:0] v;
        wr(2'd1, 8'h54);                       // cmd 5, start
        check("R2 req pulse", {7'b0, eng_req}, 8'h01);
        check("R2 cmd", {4'b0, eng_cmd}, 8'h05);
        @(negedge clk);
        check("R2 req one cycle", {7'b0, eng_req}, 8'h00);
        rd_sts(v); check("R2 busy", v, 8'h01);
        rd(2'd1, v); check("R2 start reads 0", v, 8'h14);
        check("R12 not ready while busy", {7'b0, host_ready}, 8'h00);
    endtask

    task automatic t_busy_start;
        logic [7:0] v;
        wr(2'd1, 8'h48);                       // cmd 2, start, while busy
        check("R3 no req", {7'b0, eng_req}, 8'h00);
        check("R3 cmd kept", {4'b0, eng_cmd}, 8'h05);
        rd_sts(v); check("R3 still busy", v, 8'h01);
        pulse(1, 0, 0, 0, 0, 0);
        rd_sts(v); check("R4 done sets intr", v, 8'h02);
        check("R12 intr blocks ready", {7'b0, host_ready}, 8'h00);
        wr(2'd0, 8'h02);
        rd_sts(v); check("R7 intr cleared", v, 8'h00);
        check("R12 ready again", {7'b0, host_ready}, 8'h01);
    endtask

    task automatic t_errors;
        logic [7:0] v;
        wr(2'd1, 8'h4C);
        pulse(1, 1, 1, 0, 0, 0);
        rd_sts(v); check("R5 dev+coll, no intr", v, 8'h0C);
        check("R12 fatal", {7'b0, xfer_fatal}, 8'h01);
        wr(2'd0, 8'h04);
        rd_sts(v); check("R7 single clear", v, 8'h08);
        wr(2'd0, 8'hFF);
        rd_sts(v); check("R7 clear all", v, 8'h00);
        wr(2'd1, 8'h40);
        wr(2'd0, 8'hFF);
        rd_sts(v); check("R7 busy not writable", v, 8'h01);
        pulse(1, 0, 0, 0, 0, 0);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_kill;
        logic [7:0] v;
        wr(2'd1, 8'h40);
        wr(2'd1, 8'h02);
        check("R6 abort pulse", {7'b0, eng_abort}, 8'h01);
        rd_sts(v); check("R6 failed, not busy", v, 8'h10);
        check("R6 abort one cycle", {7'b0, eng_abort}, 8'h00);
        wr(2'd1, 8'h42);
        check("R6 no req with kill", {7'b0, eng_req}, 8'h00);
        rd_sts(v); check("R6 idle with kill", v, 8'h10);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_pec;
        logic [7:0] v;
        wr(2'd2, 8'h01);
        wr(2'd1, 8'hC4);
        check("R8 pec en", {7'b0, eng_pec_en}, 8'h01);
        pulse(1, 0, 0, 0, 0, 0);
        rd_sts(v); check("R8 done no intr", v, 8'h00);
        pulse(0, 0, 0, 0, 1, 0);
        rd_sts(v); check("R8 pec end intr", v, 8'h02);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'hC0);
        check("R8 pec gated by aux", {7'b0, eng_pec_en}, 8'h00);
        pulse(1, 0, 0, 0, 0, 0);
        rd_sts(v); check("R8 no pec, done intr", v, 8'h02);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_aux;
        logic [7:0] v;
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R9 aux readback", v, 8'h03);
        check("R9 blkbuf out", {7'b0, eng_blkbuf_en}, 8'h01);
        wr(2'd2, 8'h02);
        rd(2'd2, v); check("R9 crc off", v, 8'h02);
        wr(2'd2, 8'h00);
        rd(2'd2, v); check("R9 aux off", v, 8'h00);
    endtask

    task automatic t_inuse;
        logic [7:0] v;
        wr(2'd0, 8'h40);
        rd(2'd0, v); check("R10 first read 0", v, 8'h00);
        rd(2'd0, v); check("R10 then set", v, 8'h40);
        wr(2'd0, 8'h40);
        rd(2'd0, v); check("R10 w1c", v, 8'h00);
    endtask

    task automatic t_byte_alert;
        logic [7:0] v;
        pulse(0, 0, 0, 1, 0, 0);
        rd_sts(v); check("R11 byte ignored idle", v, 8'h00);
        wr(2'd1, 8'h40);
        pulse(0, 0, 0, 1, 0, 0);
        rd_sts(v); check("R11 byte done", v, 8'h81);
        pulse(1, 0, 0, 0, 0, 0);
        wr(2'd0, 8'hFF);
        pulse(0, 0, 0, 0, 0, 1);
        rd_sts(v); check("R11 alert idle", v, 8'h20);
        check("R12 alert keeps ready", {7'b0, host_ready}, 8'h01);
        wr(2'd0, 8'hFF);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_launch();
                t_busy_start();
                t_errors();
                t_kill();
                t_pec();
                t_aux();
                t_inuse();
                t_byte_alert();
            end
            begin
                repeat (5000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule